// File: doc/BRIEF.md
# Alarm Status and Interrupt Register Unit

This block is the control and status register unit of a small timekeeping and monitoring controller. It sits on a byte-wide register bus that has an address, a read strobe, a write strobe and separate write and read data lines. It holds a writable control register and a read-only status register. The control register carries the analog channel select field, the alarm interrupt enable bit and several bits with fixed power-up values. The status register reports a conversion-update window flag, a low-battery flag and the alarm interrupt request flag.

The alarm comparison logic supplies a one-cycle alarm-match pulse. The flag it sets stays up until software touches any alarm register. A timebase tick drives a divider that marks the ADC update period. It raises the conversion-update flag for the second half of each period and issues a one-cycle update strobe at the end of the period. Two comparator inputs from the backup supply drive a low-battery flag that has hysteresis. The block drives an interrupt line and a one-hot analog channel select.

Top module: `alarm_csr`

## Requirements
- R1: After reset, the control register (address 0xB) reads 0xB0: bit 7 oscillator-off=1, bit 6 write-protect=0, bits 5 and 4 divider=1, bit 3 interrupt enable=0, bits 1:0 channel select=00. The status register reads 0x00, `irq` is 0, `chan_sel` is 000 and `adc_update` is 0.
- R2: The status register (address 0xC) reads {conversion-update, low-battery, 5'b00000, alarm flag}, with the conversion flag in bit 7, the low-battery flag in bit 6 and the alarm flag in bit 0.
- R3: An `alarm_match` pulse sets the alarm flag, and the flag is visible from the next cycle on.
- R4: `irq` is 1 exactly when the alarm flag is 1 and control bit 3 (interrupt enable) is 1. With the enable bit at 0, `irq` stays 0 whatever the flag holds.
- R5: A read or a write to any address from 0x1 to 0x5 (the alarm registers) clears the alarm flag at the next clock edge. If `alarm_match` is high in the same cycle, the flag is set instead.
- R6: `chan_sel` decodes control bits 1:0: 00 gives 000, 01 gives 001, 10 gives 010 and 11 gives 100.
- R7: A write to 0xB stores the write data with bit 2 forced to 0. Writes to 0xC are ignored. Reads of unmapped addresses, and the read data while `bus_rd` is low, return 0x00.
- R8: With a period of 488 ticks, let n be the number of ticks since reset. The conversion flag reads 1 exactly when (n mod 488) is 244 or more. In the cycle after the tick that makes n a multiple of 488, `adc_update` is 1 for one cycle and the flag is 0.
- R9: The low-battery flag goes to 1 on a cycle with `bat_low_trip` high and goes to 0 on a cycle with `bat_high_ok` high and `bat_low_trip` low. With both inputs low it holds its value. When both are high, the low input wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| alarm_match | input | 1 | One-cycle alarm-match pulse |
| tick | input | 1 | Timebase tick |
| bat_low_trip | input | 1 | Backup supply below lower threshold |
| bat_high_ok | input | 1 | Backup supply above upper threshold |
| irq | output | 1 | Interrupt request, active high |
| chan_sel | output | 3 | One-hot analog channel select |
| adc_update | output | 1 | One-cycle ADC update strobe |

## Verification
If the tick divider holds a wrong count, the conversion flag shows the error in the first status read after it happens, and `adc_update` fires on the wrong cycle within one period. An alarm flag in the wrong state shows on `irq` in the same cycle whenever the enable bit is set, and otherwise on the next status read. A control register that held a bad value would show at once on `chan_sel` or on read-back. The bench therefore compares every output on every cycle against its own model, so a fault is found in the cycle where it first becomes visible.

// File: rtl/alarm_csr_pkg.sv
package alarm_csr_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic       osc_off;
    logic       wr_prot;
    logic       div_hi;
    logic       div_lo;
    logic       alarm_ie;
    logic       rsvd;
    logic [1:0] ch_field;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = 8'hB0;

  // bit 2 is reserved and never stored
  function automatic ctrl_t ctrl_clean(input logic [DATA_W-1:0] d);
    ctrl_t c;
    c = ctrl_t'(d);
    c.rsvd = 1'b0;
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] status_word(input logic cu, input logic lobat,
                                                    input logic flag);
    return {cu, lobat, 5'b00000, flag};
  endfunction
endpackage

// File: rtl/csr_update_timer.sv
module csr_update_timer #(
  parameter int PERIOD = 488,
  parameter int WINDOW = PERIOD / 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic cu_flag,
  output logic upd_strobe
);
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST    = CW'(PERIOD - 1);
  localparam logic [CW-1:0] CU_FROM = CW'(PERIOD - WINDOW);

  logic [CW-1:0] cnt_q;
  logic          wrap_evt;

  function automatic logic [CW-1:0] cnt_advance(input logic [CW-1:0] c);
    return (c == LAST) ? '0 : c + 1'b1;
  endfunction

  assign wrap_evt = tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      cu_flag    <= 1'b0;
      upd_strobe <= 1'b0;
    end else begin
      upd_strobe <= wrap_evt;
      if (tick) begin
        cnt_q   <= cnt_advance(cnt_q);
        cu_flag <= (cnt_advance(cnt_q) >= CU_FROM);
      end
    end
  end

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_upd_clears_cu_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |-> !cu_flag);
  assert_upd_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |=> !upd_strobe);
  assert_cu_needs_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cu_flag));
endmodule

// File: rtl/csr_battery_flag.sv
module csr_battery_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic below_low,
  input  logic above_high,
  output logic lobat
);
  always_ff @(posedge clk) begin
    if (!rst_n)          lobat <= 1'b0;
    else if (below_low)  lobat <= 1'b1;
    else if (above_high) lobat <= 1'b0;
  end

  assert_lobat_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    below_low |=> lobat);
  assert_lobat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!below_low && !above_high) |=> $stable(lobat));
endmodule

// File: rtl/csr_alarm_flag.sv
module csr_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic match_pulse,
  input  logic alarm_access,
  output logic irq_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)            irq_flag <= 1'b0;
    else if (match_pulse)  irq_flag <= 1'b1;
    else if (alarm_access) irq_flag <= 1'b0;
  end

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> irq_flag);
  assert_access_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_access && !match_pulse) |=> !irq_flag);
  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !alarm_access) |=> irq_flag);
endmodule

// File: rtl/alarm_csr.sv
module alarm_csr #(
  parameter int          ADDR_W   = 4,
  parameter int          PERIOD   = 488,
  parameter int          NUM_CH   = 3,
  parameter logic [3:0]  ALARM_LO = 4'h1,
  parameter logic [3:0]  ALARM_HI = 4'h5,
  parameter logic [3:0]  CTRL_AD  = 4'hB,
  parameter logic [3:0]  STAT_AD  = 4'hC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              alarm_match,
  input  logic              tick,
  input  logic              bat_low_trip,
  input  logic              bat_high_ok,
  output logic              irq,
  output logic [NUM_CH-1:0] chan_sel,
  output logic              adc_update
);
  import alarm_csr_pkg::*;

  ctrl_t ctrl_q;
  logic  cu_flag, lobat, irq_flag;
  logic  alarm_hit, alarm_access, ctrl_wr_evt;

  assign alarm_hit    = (bus_addr >= ADDR_W'(ALARM_LO)) && (bus_addr <= ADDR_W'(ALARM_HI));
  assign alarm_access = alarm_hit && (bus_rd || bus_wr);
  assign ctrl_wr_evt  = bus_wr && (bus_addr == ADDR_W'(CTRL_AD));

  always_ff @(posedge clk) begin
    if (!rst_n)           ctrl_q <= CTRL_RESET;
    else if (ctrl_wr_evt) ctrl_q <= ctrl_clean(bus_wdata);
  end

  csr_update_timer #(.PERIOD(PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cu_flag(cu_flag), .upd_strobe(adc_update)
  );

  csr_battery_flag u_bat (
    .clk(clk), .rst_n(rst_n), .below_low(bat_low_trip),
    .above_high(bat_high_ok), .lobat(lobat)
  );

  csr_alarm_flag u_alarm (
    .clk(clk), .rst_n(rst_n), .match_pulse(alarm_match),
    .alarm_access(alarm_access), .irq_flag(irq_flag)
  );

  assign irq = irq_flag && ctrl_q.alarm_ie;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == ADDR_W'(CTRL_AD))      bus_rdata = ctrl_q;
      else if (bus_addr == ADDR_W'(STAT_AD)) bus_rdata = status_word(cu_flag, lobat, irq_flag);
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chdec
    assign chan_sel[g] = (ctrl_q.ch_field == 2'(g + 1));
  end

  assert_chsel_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_sel));
  assert_status_wr_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(STAT_AD)) |=> $stable(ctrl_q));
  assert_irq_drops_on_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_access && !alarm_match) |=> !irq);
endmodule

// File: tb/sim_alarm_csr.sv
module sim_alarm_csr;
  localparam int P = 488;
  localparam int W = 244;

  logic clk = 0, rst_n = 0;
  logic [3:0] addr = 0;
  logic rd = 0, wr = 0, match = 0, tck = 0, blow = 0, bhigh = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq, upd;
  logic [2:0] chsel;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // model state
  logic [7:0] m_ctrl = 8'hB0;
  logic m_flag = 0, m_lobat = 0, m_upd = 0;
  int   m_ticks = 0;

  alarm_csr u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .alarm_match(match), .tick(tck),
    .bat_low_trip(blow), .bat_high_ok(bhigh), .irq(irq), .chan_sel(chsel),
    .adc_update(upd)
  );

  always #5 clk = ~clk;

  function automatic logic [2:0] exp_chsel(input logic [1:0] f);
    case (f)
      2'd1: return 3'b001;
      2'd2: return 3'b010;
      2'd3: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic exp_cu(input int t);
    return (t % P) >= W;
  endfunction

  function automatic logic [7:0] exp_rdata(input logic r, input logic [3:0] a);
    if (!r) return 8'h00;
    if (a == 4'hB) return m_ctrl;
    if (a == 4'hC) return {exp_cu(m_ticks), m_lobat, 5'b0, m_flag};
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, expv, $time);
    end
  endtask

  // drive inputs at negedge, check outputs, then clock the model
  task automatic cycle(input logic [3:0] a, input logic r, input logic w,
                       input logic [7:0] d, input logic m, input logic t,
                       input logic bl, input logic bh);
    @(negedge clk);
    addr = a; rd = r; wr = w; wdata = d; match = m; tck = t; blow = bl; bhigh = bh;
    #1;
    chk("R2/R7/R8 rdata", rdata, exp_rdata(r, a));
    chk("R4 irq", {7'b0, irq}, {7'b0, m_flag & m_ctrl[3]});
    chk("R6 chan_sel", {5'b0, chsel}, {5'b0, exp_chsel(m_ctrl[1:0])});
    chk("R8 adc_update", {7'b0, upd}, {7'b0, m_upd});
    @(posedge clk);
    m_upd = t && (((m_ticks + 1) % P) == 0);
    if (t) m_ticks++;
    if (m) m_flag = 1;
    else if ((r || w) && a >= 4'h1 && a <= 4'h5) m_flag = 0;
    if (bl) m_lobat = 1;
    else if (bh) m_lobat = 0;
    if (w && a == 4'hB) m_ctrl = d & 8'hFB;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset values
    cycle(4'hB, 1, 0, 0, 0, 0, 0, 0);
    chk("R1 ctrl reset", rdata, 8'hB0);
    cycle(4'hC, 1, 0, 0, 0, 0, 0, 0);
    chk("R1 status reset", rdata, 8'h00);
    // R3 set, R4 gated off then on
    cycle(4'h0, 0, 0, 0, 1, 0, 0, 0);
    cycle(4'hC, 1, 0, 0, 0, 0, 0, 0);
    chk("R3 flag set", rdata, 8'h01);
    chk("R4 irq masked", {7'b0, irq}, 8'h00);
    cycle(4'hB, 0, 1, 8'h0F, 0, 0, 0, 0);
    cycle(4'hB, 1, 0, 0, 0, 0, 0, 0);
    chk("R7 bit2 forced 0", rdata, 8'h0B);
    chk("R4 irq enabled", {7'b0, irq}, 8'h01);
    chk("R6 ch 11", {5'b0, chsel}, 8'h04);
    // R7 status write ignored, unmapped read
    cycle(4'hC, 0, 1, 8'hFF, 0, 0, 0, 0);
    cycle(4'hB, 1, 0, 0, 0, 0, 0, 0);
    chk("R7 status write ignored", rdata, 8'h0B);
    cycle(4'hE, 1, 0, 0, 0, 0, 0, 0);
    chk("R7 unmapped zero", rdata, 8'h00);
    // R5 set wins over clear, then clear by write at top of range
    cycle(4'h3, 1, 0, 0, 1, 0, 0, 0);
    cycle(4'hC, 1, 0, 0, 0, 0, 0, 0);
    chk("R5 set wins", rdata, 8'h01);
    cycle(4'h5, 0, 1, 8'h00, 0, 0, 0, 0);
    cycle(4'hC, 1, 0, 0, 0, 0, 0, 0);
    chk("R5 clear", rdata, 8'h00);
    // R9 hysteresis
    cycle(4'h0, 0, 0, 0, 0, 0, 1, 1);
    cycle(4'hC, 1, 0, 0, 0, 0, 0, 0);
    chk("R9 low wins", rdata, 8'h40);
    cycle(4'h0, 0, 0, 0, 0, 0, 0, 1);
    cycle(4'hC, 1, 0, 0, 0, 0, 0, 0);
    chk("R9 high clears", rdata, 8'h00);
    // R8 full period of ticks, status read every cycle
    for (int i = 0; i < P + 2; i++) cycle(4'hC, 1, 0, 0, 0, 1, 0, 0);
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      logic r, w;
      int op;
      a  = 4'($urandom_range(0, 15));
      op = $urandom_range(0, 9);
      r  = (op < 5);
      w  = (op >= 8) && (a != 4'hB || $urandom_range(0, 3) == 0);
      cycle(a, r, w, 8'($urandom), $urandom_range(0, 15) == 0,
            $urandom_range(0, 1) == 1, $urandom_range(0, 7) == 0,
            $urandom_range(0, 7) == 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule